// File: doc/BRIEF.md
# Double-Buffered Scanned LED Matrix Driver

This block drives a large LED array that is multiplexed by rows: eleven scan lines share 1728 column lines, and each line is lit in turn. Column data for the next row to be shown is written by a host one byte at a time into a staging bank of 216 addressable byte latches. Staging writes never touch what is currently on the column lines. A single transfer strobe copies the whole staging bank at once into a second rank of output registers, and those registers drive the columns.

A free-running scan sequencer steps through the rows at a fixed, parameterised dwell time per row. Each row slot starts with a short guard interval in which every row enable is off, so the change of row never shows the previous row's columns. A transfer also forces a blanking window on all row enables while the new column pattern settles. Every row therefore gets the same lit time, one eleventh of the refresh period less the guard. A host normally watches the one-hot row enables, loads the staging bank for the coming row, and strobes the transfer near the row change.

Top module: `lmx_matrix_drv`

## Requirements
- R1: While reset is held and at the first sample after it, every row enable is low and every column output is zero; the scan starts in row 0 at the start of its slot.
- R2: A write with `wr_en` high to a byte address k below NUM_BYTES stores `wr_data` in staging byte k; after the next transfer, column output 8k+i carries bit i of that byte (bit 0 at the lowest column of the byte).
- R3: The column outputs change only on a clock edge that samples `xfer` high; staging writes alone leave them unchanged.
- R4: A write to a byte address of NUM_BYTES or above is ignored: no staging byte changes.
- R5: When a write and a transfer are sampled on the same edge, the transfer copies the staging contents from before that write; the written byte reaches the columns at the following transfer.
- R6: At most one row enable is high at any time; bit r of `row_en` belongs to row r, rows follow in the order 0, 1, ..., NUM_ROWS-1 and wrap back to 0, and each row slot lasts DWELL_CYCLES clock cycles counted from reset.
- R7: Within each row slot the first GUARD_CYCLES cycles have all row enables low and the remaining cycles have the slot's row enable high, so without transfers each row is lit DWELL_CYCLES-GUARD_CYCLES cycles out of every NUM_ROWS*DWELL_CYCLES.
- R8: For the XFER_BLANK cycles after an edge that samples `xfer` high, every row enable is low; a new transfer restarts that window, and transfers never shift the row timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Staging byte write strobe |
| wr_addr | input | ADDR_W | Staging byte address, 0 to NUM_BYTES-1 valid |
| wr_data | input | 8 | Byte written to staging |
| xfer | input | 1 | Copies the whole staging bank into the column registers |
| col_out | output | NUM_BYTES*8 | Column line drive from the output registers |
| row_en | output | NUM_ROWS | One-hot (or all-off) row enables |

## Verification
The transfer blanking and the row-change guard can fall in the same cycle, and a transfer can also coincide with a staging write. The bench provokes the first by timing the transfer strobe onto the exact edge where the row counter wraps, and onto edges inside a guard interval, and judges them by comparing `row_en` every cycle against an expectation computed from the cycle count since reset and the edge of the latest transfer. The second is provoked by asserting a write and the transfer together and judged from the column outputs after that transfer and after the next one.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
   localparam int LMX_BYTE_W = 8;

   typedef logic [LMX_BYTE_W-1:0] lmx_byte_t;

   typedef enum logic [1:0] {
      LMX_PH_GUARD  = 2'd0,
      LMX_PH_LIT    = 2'd1,
      LMX_PH_XBLANK = 2'd2
   } lmx_phase_e;
endpackage

// File: rtl/lmx_stage_bank.sv
module lmx_stage_bank
   import lmx_pkg::*;
#(
   parameter int NUM_BYTES = 216,
   parameter int ADDR_W    = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  lmx_byte_t                        wr_data,
   output logic [NUM_BYTES*LMX_BYTE_W-1:0]  stage_flat
);
   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      lmx_byte_t byte_q;
      logic      hit;

      assign hit = wr_en && (wr_addr == ADDR_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (hit) begin
            byte_q <= wr_data;
         end
      end

      assign stage_flat[b*LMX_BYTE_W +: LMX_BYTE_W] = byte_q;
   end
endmodule

// File: rtl/lmx_col_reg.sv
module lmx_col_reg #(
   parameter int WIDTH = 1728
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end
endmodule

// File: rtl/lmx_scan_seq.sv
module lmx_scan_seq
   import lmx_pkg::*;
#(
   parameter int NUM_ROWS     = 11,
   parameter int DWELL_CYCLES = 1000,
   parameter int GUARD_CYCLES = 4,
   parameter int XFER_BLANK   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                xfer,
   output logic [NUM_ROWS-1:0] row_en
);
   localparam int ROW_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
   localparam int TICK_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
   localparam int XB_W   = $clog2(XFER_BLANK + 1);

   localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(NUM_ROWS - 1);
   localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(DWELL_CYCLES - 1);
   localparam logic [TICK_W-1:0] GUARD_END = TICK_W'(GUARD_CYCLES);
   localparam logic [XB_W-1:0]   XB_LOAD   = XB_W'(XFER_BLANK);

   logic [ROW_W-1:0]  row_q;
   logic [TICK_W-1:0] tick_q;
   logic [XB_W-1:0]   xb_q;
   lmx_phase_e        phase;

   // Row slot timing runs freely; transfers only load the blanking counter.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         tick_q <= '0;
      end else if (tick_q == LAST_TICK) begin
         tick_q <= '0;
         row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xb_q <= '0;
      end else if (xfer) begin
         xb_q <= XB_LOAD;
      end else if (xb_q != '0) begin
         xb_q <= xb_q - 1'b1;
      end
   end

   always_comb begin
      if (xb_q != '0) begin
         phase = LMX_PH_XBLANK;
      end else if (tick_q < GUARD_END) begin
         phase = LMX_PH_GUARD;
      end else begin
         phase = LMX_PH_LIT;
      end
   end

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      assign row_en[r] = (phase == LMX_PH_LIT) && (row_q == ROW_W'(r));
   end
endmodule

// File: rtl/lmx_matrix_drv.sv
module lmx_matrix_drv
   import lmx_pkg::*;
#(
   parameter  int NUM_ROWS     = 11,
   parameter  int NUM_BYTES    = 216,
   parameter  int DWELL_CYCLES = 1000,
   parameter  int GUARD_CYCLES = 4,
   parameter  int XFER_BLANK   = 4,
   localparam int NUM_COLS     = NUM_BYTES * LMX_BYTE_W,
   localparam int ADDR_W       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_data,
   input  logic                xfer,
   output logic [NUM_COLS-1:0] col_out,
   output logic [NUM_ROWS-1:0] row_en
);
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("lmx_matrix_drv: NUM_ROWS must be at least 2");
   end
   if (NUM_BYTES < 1) begin : g_bad_bytes
      $error("lmx_matrix_drv: NUM_BYTES must be at least 1");
   end
   if (DWELL_CYCLES < 2) begin : g_bad_dwell
      $error("lmx_matrix_drv: DWELL_CYCLES must be at least 2");
   end
   if (GUARD_CYCLES < 1 || GUARD_CYCLES >= DWELL_CYCLES) begin : g_bad_guard
      $error("lmx_matrix_drv: GUARD_CYCLES must lie in 1..DWELL_CYCLES-1");
   end
   if (XFER_BLANK < 1) begin : g_bad_xblank
      $error("lmx_matrix_drv: XFER_BLANK must be at least 1");
   end

   logic [NUM_COLS-1:0] stage_flat;

   lmx_stage_bank #(
      .NUM_BYTES (NUM_BYTES),
      .ADDR_W    (ADDR_W)
   ) stage_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .stage_flat (stage_flat)
   );

   lmx_col_reg #(
      .WIDTH (NUM_COLS)
   ) colreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (xfer),
      .d     (stage_flat),
      .q     (col_out)
   );

   lmx_scan_seq #(
      .NUM_ROWS     (NUM_ROWS),
      .DWELL_CYCLES (DWELL_CYCLES),
      .GUARD_CYCLES (GUARD_CYCLES),
      .XFER_BLANK   (XFER_BLANK)
   ) scan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer   (xfer),
      .row_en (row_en)
   );
endmodule

// File: rtl/lmx_matrix_drv_chk.sv
module lmx_matrix_drv_chk #(
   parameter int NUM_ROWS = 11,
   parameter int NUM_COLS = 1728
) (
   input logic                clk,
   input logic                rst_n,
   input logic                xfer,
   input logic [NUM_COLS-1:0] col_out,
   input logic [NUM_ROWS-1:0] row_en
);
   // R6: never more than one row lit
   a_r6_onehot_rows: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_en));

   // R3: columns hold unless a transfer is sampled
   a_r3_cols_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(col_out));

   // R8: the cycle after a transfer is dark
   a_r8_xfer_dark: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (row_en == '0));

   // R7: a lit row is never replaced directly by another row
   a_r7_guard_between_rows: assert property (@(posedge clk) disable iff (!rst_n)
      (row_en != '0) |=> ((row_en == '0) || (row_en == $past(row_en))));
endmodule

bind lmx_matrix_drv lmx_matrix_drv_chk #(
   .NUM_ROWS (NUM_ROWS),
   .NUM_COLS (NUM_COLS)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .xfer    (xfer),
   .col_out (col_out),
   .row_en  (row_en)
);

// File: tb/lmx_matrix_drv_tb.sv
`timescale 1ns/1ps
module lmx_matrix_drv_tb_top;
   localparam int NR = 11;
   localparam int NB = 6;
   localparam int D  = 8;
   localparam int G  = 2;
   localparam int XB = 3;
   localparam int NC = NB * 8;
   localparam int AW = $clog2(NB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          xfer = 1'b0;
   logic [NC-1:0] col_out;
   logic [NR-1:0] row_en;

   int checks = 0;
   int errors = 0;
   int k = 0;        // edges since reset release
   int kx = 0;       // edge index of latest transfer
   bit hx = 0;
   bit scan_on = 0;
   logic [7:0] exp_stage [NB];
   logic [7:0] exp_col [NB];

   always #10 clk = ~clk;

   lmx_matrix_drv #(
      .NUM_ROWS (NR), .NUM_BYTES (NB), .DWELL_CYCLES (D),
      .GUARD_CYCLES (G), .XFER_BLANK (XB)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .xfer (xfer), .col_out (col_out), .row_en (row_en)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         k <= k + 1;
         if (xfer) begin
            kx <= k + 1;
            hx <= 1;
         end
      end
   end

   function automatic logic [NR-1:0] exp_rows(int n);
      if ((n % D) < G) return '0;
      if (hx && (n - kx) < XB) return '0;
      return NR'(1) << ((n / D) % NR);
   endfunction

   // R6 R7 R8: row enables compared every cycle
   always @(negedge clk) begin
      if (scan_on) begin
         checks++;
         if (row_en !== exp_rows(k)) begin
            errors++;
            $display("FAIL R6 R7 R8 row_en at edge %0d: got %b exp %b", k, row_en, exp_rows(k));
         end
      end
   end

   task automatic chk_cols(string tag);
      for (int b = 0; b < NB; b++) begin
         checks++;
         if (col_out[b*8 +: 8] !== exp_col[b]) begin
            errors++;
            $display("FAIL %s col byte %0d: got %h exp %h", tag, b, col_out[b*8 +: 8], exp_col[b]);
         end
      end
   endtask

   task automatic wr(int a, logic [7:0] d, bit with_x);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; xfer = with_x;
      @(negedge clk);
      wr_en = 1'b0; xfer = 1'b0;
      if (with_x) for (int b = 0; b < NB; b++) exp_col[b] = exp_stage[b];
      if (a < NB) exp_stage[a] = d;
   endtask

   task automatic do_xfer();
      @(negedge clk);
      xfer = 1'b1;
      @(negedge clk);
      xfer = 1'b0;
      for (int b = 0; b < NB; b++) exp_col[b] = exp_stage[b];
   endtask

   initial begin
      for (int b = 0; b < NB; b++) begin exp_stage[b] = '0; exp_col[b] = '0; end
      repeat (3) @(negedge clk);
      // R1: state held in reset
      checks++;
      if (row_en !== '0 || col_out !== '0) begin
         errors++;
         $display("FAIL R1 reset outputs: row_en %b col %h exp 0 0", row_en, col_out);
      end
      rst_n = 1'b1;
      scan_on = 1;
      @(negedge clk);
      chk_cols("R1");

      // R2: fill all bytes, transfer, check bit placement
      for (int b = 0; b < NB; b++) wr(b, 8'(8'h1D * (b + 1) ^ (1 << b)), 0);
      do_xfer();
      chk_cols("R2");
      checks++;
      if (col_out[0] !== exp_stage[0][0] || col_out[NC-1] !== exp_stage[NB-1][7]) begin
         errors++;
         $display("FAIL R2 edge columns: got %b %b exp %b %b", col_out[0], col_out[NC-1],
                  exp_stage[0][0], exp_stage[NB-1][7]);
      end

      // R3: rewrite staging without transfer, columns unchanged
      for (int b = 0; b < NB; b++) wr(b, ~exp_stage[b], 0);
      repeat (5) @(negedge clk);
      chk_cols("R3");

      // R4: out-of-range writes ignored
      for (int a = NB; a < (1 << AW); a++) wr(a, 8'hA5, 0);
      do_xfer();
      chk_cols("R4");

      // R5: write and transfer on the same edge
      wr(0, 8'h3C, 1);
      chk_cols("R5 same-edge");
      do_xfer();
      chk_cols("R5 next-transfer");

      // R8: transfer landing on the row-wrap edge
      while (((k + 1) % D) != 0) @(negedge clk);
      do_xfer();
      repeat (2 * D) @(negedge clk);
      // R8: transfer inside a guard interval, then a back-to-back pair
      while (((k + 1) % D) != 1) @(negedge clk);
      do_xfer();
      do_xfer();
      chk_cols("R8");

      // R7: lit cycles per row over one whole frame
      while ((k % (NR * D)) != 0 || (k - kx) < XB) @(negedge clk);
      begin
         int lit [NR];
         for (int r = 0; r < NR; r++) lit[r] = 0;
         for (int c = 0; c < NR * D; c++) begin
            for (int r = 0; r < NR; r++) if (row_en[r]) lit[r]++;
            @(negedge clk);
         end
         for (int r = 0; r < NR; r++) begin
            checks++;
            if (lit[r] != D - G) begin
               errors++;
               $display("FAIL R7 duty row %0d: got %0d exp %0d", r, lit[r], D - G);
            end
         end
      end

      // R6: several more full frames of plain scanning
      repeat (3 * NR * D) @(negedge clk);
      scan_on = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule